// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Selector

This block chooses which interrupt a small processor core services next. Sixteen interrupt sources each raise a one-cycle request pulse. The block latches every pulse into a pending flag. A flag competes for service only when two conditions hold: its own enable bit is 1, and the global enable bit is 1. Among the competing flags, the source with the lowest index wins. The core receives a request line, a vector position and a vector address. The address is the position multiplied by a slot size, which is a parameter.

Vector position 0 belongs to reset. Reset cannot be masked and has the highest priority. Source `i` sits at position `i+1`, so a lower position means higher priority. The sources run in this order:

- Index 0: external request 0.
- Index 1: external request 1.
- Index 2: timer-2 compare.
- Index 3: timer-2 overflow.
- Index 4: timer-1 capture.
- Index 5: timer-1 compare A.
- Index 6: timer-1 compare B.
- Higher indices: the remaining peripherals, ending with the serial-transfer-complete and receive-complete sources.

The handshake works as follows. When the core acknowledges a request, the block clears the winning source's pending flag and clears the global enable bit. A return strobe from the core sets the global enable bit again.

Top module: `irq_vector_sel`

## Requirements
- R1: After a synchronous active-low reset, the following are all 0: `pending`, the individual enables, `gie`, `irq_req`, `vec_idx` and `vec_addr`.
- R2: A 1 on `src_pulse[i]` sets `pending[i]` at the next clock edge. The flag then stays set, whether or not source `i` is masked, until that source is acknowledged.
- R3: `irq_req` is 1 exactly when `gie` is 1 and at least one bit of `pending & enables` is 1. A pending source whose enable is 0 never wins.
- R4: While `irq_req` is 1, `vec_idx` equals i+1, where i is the lowest index that is both pending and enabled. Position 0 is reserved for reset. While `irq_req` is 0, `vec_idx` is 0.
- R5: `vec_addr` equals `vec_idx` times the parameter `SLOT_WORDS`.
- R6: When `irq_ack` is 1 while `irq_req` is 1, the next edge does two things: it clears the winner's pending flag, and it clears `gie`. All other pending flags are kept.
- R7: When `irq_ack` is 1 while `irq_req` is 0, nothing changes: `pending` and `gie` keep their values.
- R8: `irq_ret` sets `gie` at the next edge. If an accepted acknowledge arrives in the same cycle, the acknowledge wins and `gie` becomes 0.
- R9: `gie_wr` loads `gie_wdata` into `gie`, unless an accepted acknowledge or a return arrives in the same cycle. `en_wr` loads `en_wdata` into the individual enables, with bit i enabling source i.
- R10: When a new pulse on source i arrives in the same cycle as the acknowledge that clears source i, `pending[i]` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | NUM_SRC | One-cycle request pulses, one bit per source |
| en_wr | input | 1 | Write strobe for the individual enables |
| en_wdata | input | NUM_SRC | New individual enable bits |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core returns from an interrupt handler |
| irq_req | output | 1 | An enabled source is pending and global enable is set |
| vec_idx | output | IDX_W | Vector position of the winner, 0 when idle |
| vec_addr | output | ADDR_W | Vector address, equal to the position times SLOT_WORDS |
| gie | output | 1 | Current global enable |
| pending | output | NUM_SRC | Latched pending flags |

## Verification
The hardest case to reach from the ports is a collision at a single clock edge: a source is acknowledged and cleared while a fresh pulse for that same source arrives. A second hard case is an acknowledge and a return strobe in the same cycle. To reach either case, the stimulus first builds a known set of pending flags, with some of them held back by the global and individual masks. It then opens the masks step by step so that a chosen source wins. Only then does it fire the conflicting strobes together. Observing the pending flags and the global enable one cycle later shows which update took precedence.

// File: rtl/irq_sel_pkg.sv
// Package: shared types for the interrupt vector selector.
// Assumes: nothing beyond SystemVerilog 2017.
package irq_sel_pkg;

    // Update applied to the global enable register in a given cycle.
    typedef enum logic [1:0] {
        GIE_HOLD  = 2'd0,
        GIE_CLEAR = 2'd1,
        GIE_SET   = 2'd2,
        GIE_LOAD  = 2'd3
    } gie_op_e;

endpackage

// File: rtl/irq_pend_bank.sv
// Module: bank of pending-flag latches, one flop per source.
// A set pulse wins over a clear in the same cycle, so a fresh request
// that arrives at the same edge as its own acknowledge is not lost.
// Assumes: set and clear are single-cycle, synchronous to clk.
module irq_pend_bank #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        // Latch one source's request; set has precedence over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                pend_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_prio_enc.sv
// Module: fixed-priority encoder.
// The lowest set bit of req_i wins. The module reports the winner as a
// one-hot grant and as a vector position (bit index + 1), with position 0
// left for reset.
// Assumes: req_i is already masked; purely combinational.
module irq_prio_enc #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   pos_o
);

    // Find the lowest requesting index; scanning downward leaves it last.
    always_comb begin
        pos_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pos_o = IDX_W'(i + 1);
            end
        end
    end

    // Isolate the lowest set bit as a one-hot grant.
    assign grant_o = req_i & (~req_i + NUM_SRC'(1));
    assign any_o   = |req_i;

endmodule

// File: rtl/irq_gie_ctrl.sv
// Module: global interrupt-enable register.
// Order of precedence: an accepted acknowledge clears it, else a return
// sets it, else a software write loads it.
// Assumes: take_i is already qualified with an active request.
module irq_gie_ctrl
    import irq_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic ret_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic gie_o
);

    gie_op_e op;

    // Pick this cycle's update by precedence.
    always_comb begin
        if (take_i) begin
            op = GIE_CLEAR;
        end else if (ret_i) begin
            op = GIE_SET;
        end else if (wr_i) begin
            op = GIE_LOAD;
        end else begin
            op = GIE_HOLD;
        end
    end

    // Apply the selected update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o <= 1'b0;
        end else begin
            unique case (op)
                GIE_CLEAR: gie_o <= 1'b0;
                GIE_SET:   gie_o <= 1'b1;
                GIE_LOAD:  gie_o <= wdata_i;
                default:   gie_o <= gie_o;
            endcase
        end
    end

endmodule

// File: rtl/irq_vector_sel.sv
// Module: fixed-priority interrupt vector selector (top).
// Latches request pulses, masks them with the individual and global
// enables, presents the lowest-index winner as a vector position and
// address, and runs the acknowledge/return handshake.
// Assumes: vector position 0 is reset; source i sits at position i+1.
module irq_vector_sel #(
    parameter  int NUM_SRC    = 16,
    parameter  int SLOT_WORDS = 1,
    localparam int IDX_W      = $clog2(NUM_SRC + 1),
    localparam int ADDR_W     = $clog2((NUM_SRC + 1) * SLOT_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               en_wr,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [IDX_W-1:0]   vec_idx,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               gie,
    output logic [NUM_SRC-1:0] pending
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] live_req;
    logic [NUM_SRC-1:0] grant_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic               ack_take;

    // Hold the individual enable bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    // Mask the pending flags by both levels of enable.
    assign live_req = pending & en_q & {NUM_SRC{gie}};

    irq_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_enc (
        .req_i   (live_req),
        .any_o   (irq_req),
        .grant_o (grant_vec),
        .pos_o   (vec_idx)
    );

    // Accept an acknowledge only while a request is shown.
    assign ack_take = irq_ack & irq_req;
    assign clr_vec  = grant_vec & {NUM_SRC{ack_take}};

    irq_pend_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_pulse),
        .clr_i  (clr_vec),
        .pend_o (pending)
    );

    irq_gie_ctrl u_gie (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (ack_take),
        .ret_i   (irq_ret),
        .wr_i    (gie_wr),
        .wdata_i (gie_wdata),
        .gie_o   (gie)
    );

    // Scale the position into a program-memory address.
    assign vec_addr = ADDR_W'(vec_idx) * ADDR_W'(SLOT_WORDS);

endmodule

// File: rtl/irq_vector_sel_chk.sv
// Module: property checker for irq_vector_sel, attached by bind.
// Assumes: rst_n is held low for at least one edge at start-up.
module irq_vector_sel_chk #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic               irq_ack,
    input logic               irq_ret,
    input logic               irq_req,
    input logic [IDX_W-1:0]   vec_idx,
    input logic               gie,
    input logic [NUM_SRC-1:0] pending,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] grant_vec
);

    // R2
    pulse_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse) |=> ((pending & $past(src_pulse)) == $past(src_pulse)));

    // R3
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gie);

    // R4
    grant_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($onehot0(grant_vec) && ((grant_vec & pending & en_q) == grant_vec)
                     && ((pending & en_q & (grant_vec - NUM_SRC'(1))) == '0)));

    // R4
    idle_pos_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (vec_idx == '0));

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (!gie && ((pending & ~$past(src_pulse) & $past(grant_vec)) == '0)));

    // R8
    ret_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_ack && irq_req)) |=> gie);

endmodule

bind irq_vector_sel irq_vector_sel_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .irq_req   (irq_req),
    .vec_idx   (vec_idx),
    .gie       (gie),
    .pending   (pending),
    .en_q      (en_q),
    .grant_vec (grant_vec)
);

// File: tb/irq_vector_sel_tb.sv
// Directed bench for irq_vector_sel, one task per scenario.
module irq_vector_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 16;
    localparam int SLOT       = 2;
    localparam int IW         = $clog2(NSRC + 1);
    localparam int AW         = $clog2((NSRC + 1) * SLOT);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_pulse;
    logic            en_wr;
    logic [NSRC-1:0] en_wdata;
    logic            gie_wr;
    logic            gie_wdata;
    logic            irq_ack;
    logic            irq_ret;
    logic            irq_req;
    logic [IW-1:0]   vec_idx;
    logic [AW-1:0]   vec_addr;
    logic            gie;
    logic [NSRC-1:0] pending;

    int n_run  = 0;
    int n_fail = 0;

    irq_vector_sel #(.NUM_SRC(NSRC), .SLOT_WORDS(SLOT)) u_dut (
        .clk, .rst_n, .src_pulse, .en_wr, .en_wdata, .gie_wr, .gie_wdata,
        .irq_ack, .irq_ret, .irq_req, .vec_idx, .vec_addr, .gie, .pending
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One clock edge; inputs change and outputs are sampled at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        src_pulse = '0; en_wr = 0; en_wdata = '0; gie_wr = 0; gie_wdata = 0;
        irq_ack = 0; irq_ret = 0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] p);
        src_pulse = p; step(); src_pulse = '0;
    endtask

    task automatic expect_out(input string tag, input logic req, input int idx,
                              input logic g, input logic [NSRC-1:0] pend);
        chk({tag, " irq_req"}, 32'(irq_req), 32'(req));
        chk({tag, " vec_idx"}, 32'(vec_idx), 32'(idx));
        chk({tag, " vec_addr R5"}, 32'(vec_addr), 32'(idx * SLOT));
        chk({tag, " gie"}, 32'(gie), 32'(g));
        chk({tag, " pending"}, 32'(pending), 32'(pend));
    endtask

    task automatic t_reset();
        rst_n = 0; idle_inputs(); step(); step(); rst_n = 1; step();
        expect_out("R1 reset", 0, 0, 0, 16'h0000);
    endtask

    task automatic t_latch_masked();
        pulse(16'h0020);
        expect_out("R2 latch while masked", 0, 0, 0, 16'h0020);
        step(); step(); step();
        expect_out("R2 held", 0, 0, 0, 16'h0020);
        en_wdata = 16'h0020; en_wr = 1; step(); en_wr = 0;
        expect_out("R3 gie off", 0, 0, 0, 16'h0020);
        gie_wdata = 1; gie_wr = 1; step(); gie_wr = 0;
        expect_out("R3 R9 gie on", 1, 6, 1, 16'h0020);
    endtask

    task automatic t_priority();
        pulse(16'h0204);
        expect_out("R3 lower source not enabled", 1, 6, 1, 16'h0224);
        en_wdata = 16'hFFFF; en_wr = 1; step(); en_wr = 0;
        expect_out("R4 lowest wins", 1, 3, 1, 16'h0224);
        en_wdata = 16'hFFFB; en_wr = 1; step(); en_wr = 0;
        expect_out("R4 R9 masked winner skipped", 1, 6, 1, 16'h0224);
        en_wdata = 16'hFFFF; en_wr = 1; step(); en_wr = 0;
        expect_out("R4 restored", 1, 3, 1, 16'h0224);
    endtask

    task automatic t_ack();
        irq_ack = 1; step(); irq_ack = 0;
        expect_out("R6 ack clears winner and gie", 0, 0, 0, 16'h0220);
        irq_ack = 1; step(); irq_ack = 0;
        expect_out("R7 ack without request ignored", 0, 0, 0, 16'h0220);
    endtask

    task automatic t_ret();
        irq_ret = 1; step(); irq_ret = 0;
        expect_out("R8 return sets gie", 1, 6, 1, 16'h0220);
        irq_ack = 1; irq_ret = 1; step(); irq_ack = 0; irq_ret = 0;
        expect_out("R8 ack beats return", 0, 0, 0, 16'h0200);
    endtask

    task automatic t_gie_wr();
        gie_wdata = 1; gie_wr = 1; step(); gie_wr = 0;
        expect_out("R9 write gie 1", 1, 10, 1, 16'h0200);
        gie_wdata = 0; gie_wr = 1; step(); gie_wr = 0;
        expect_out("R9 write gie 0", 0, 0, 0, 16'h0200);
        gie_wdata = 1; gie_wr = 1; step(); gie_wr = 0;
    endtask

    task automatic t_pulse_vs_ack();
        src_pulse = 16'h0200; irq_ack = 1; step(); src_pulse = '0; irq_ack = 0;
        expect_out("R10 new pulse survives ack", 0, 0, 0, 16'h0200);
        irq_ret = 1; step(); irq_ret = 0;
        irq_ack = 1; step(); irq_ack = 0;
        expect_out("R6 last flag cleared", 0, 0, 0, 16'h0000);
    endtask

    task automatic t_edges();
        pulse(16'h8000);
        irq_ret = 1; step(); irq_ret = 0;
        expect_out("R4 R5 highest index", 1, 16, 1, 16'h8000);
        pulse(16'h0001);
        expect_out("R4 R5 index zero", 1, 1, 1, 16'h8001);
    endtask

    task automatic t_reset_mid();
        en_wdata = 16'h0001; en_wr = 1; rst_n = 0; step(); rst_n = 1; en_wr = 0;
        expect_out("R1 mid-run reset", 0, 0, 0, 16'h0000);
        gie_wdata = 1; gie_wr = 1; step(); gie_wr = 0;
        pulse(16'h0001);
        expect_out("R1 enables cleared", 0, 0, 1, 16'h0001);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; idle_inputs();
        @(negedge clk);
        t_reset();
        t_latch_masked();
        t_priority();
        t_ack();
        t_ret();
        t_gie_wr();
        t_pulse_vs_ack();
        t_edges();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule